// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block holds the software-visible registers of a two-channel bus-master disk DMA engine. A host reaches it through a small register port: a word address, four byte enables and 32-bit write data. Each channel owns an eight-byte window. Byte 0 is a control byte, byte 2 a status byte and bytes 4 to 7 the physical address of the descriptor table. Channel 0 sits at bytes 0–7 and channel 1 at bytes 8–15. Because each byte lane maps to one byte offset, the pointer can be written as a byte, a halfword or a word.

Toward the transfer engine, the block turns control writes into single-cycle go and stop pulses. It reports the transfer direction and the current table pointer, and it absorbs completion and error strobes into the status byte. Bytes 1 and 3 of each window are optional per-channel extension bytes. They are selected by a parameter. When they are absent those offsets, like any unmapped offset, read as all ones.

Top module: `bmdma_regfile`

## Requirements
- R1: After reset the control byte, status byte, table pointer and current pointer of every channel read zero, and no go or stop pulse is driven.
- R2: A write to the control byte (byte lane 0 of a channel's word 0) keeps only bit 0 (go) and bit 3 (direction, driven on `eng_dir`). Every other control bit reads as zero.
- R3: A control write with bit 0 clear produces a one-cycle stop pulse on the following cycle. In that same cycle the status active flag (status bit 0) reads clear.
- R4: A control write with bit 0 set while status bit 0 is clear sets status bit 0 and produces exactly one single-cycle go pulse. If status bit 0 is already set, no go pulse is produced and the flag stays set.
- R5: A status write (lane 2 of word 0) loads bits 5 and 6 from the data and leaves bit 0 unchanged. Bits 1 and 2 are cleared where the written data holds a 1 and kept elsewhere. Bits 3, 4 and 7 always read zero.
- R6: A completion strobe sets status bit 2 and clears bit 0, and an error strobe sets bit 1. A strobe wins over a same-cycle write-one-to-clear of the same bit. A go in the same cycle as a completion leaves bit 0 set.
- R7: The table pointer (word 1, lane k holding bits 8k+7:8k) accepts any combination of byte lanes. Its bits 1:0 always read zero.
- R8: Every pointer write copies the complete updated pointer to `eng_cur_ptr` of that channel in the following cycle.
- R9: Bytes 1 and 3 of word 0 read 0xFF when the extension option is off. When it is on, they are plain per-channel read/write bytes.
- R10: A write to one channel changes no register or pulse of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_waddr | input | 2 | Word address: bit 1 selects channel, bit 0 selects control/status word or pointer word |
| bus_be | input | 4 | Byte enables, lane k is byte offset k of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| eng_start | output | 2 | One-cycle go pulse per channel |
| eng_cancel | output | 2 | One-cycle stop pulse per channel |
| eng_dir | output | 2 | Direction bit per channel |
| eng_cur_ptr | output | 64 | Current table pointer, channel c at bits 32c+31:32c |
| eng_done | input | 2 | Completion strobe per channel |
| eng_err | input | 2 | Error strobe per channel |

## Verification
The hardest situations to reach from the ports are collisions, where an engine strobe lands in the same cycle as a status write that clears the same bit, or as a control write that starts or stops the channel. Random steps drive strobes and writes together with independent probabilities, so these overlaps occur many times. Directed steps also force the go-versus-completion and strobe-versus-clear cases once each. A second instance with the extension bytes enabled shares the same stimulus, so both read paths for bytes 1 and 3 are compared under one sequence.

// File: rtl/bmdma_pkg.sv
// Package: shared bit positions and write-select type for the DMA register file.
// Assumes 8-byte channel windows made of two 32-bit words.
package bmdma_pkg;
    localparam int CTL_GO      = 0;
    localparam int CTL_DIR     = 3;
    localparam logic [7:0] CTL_KEEP = 8'h09;
    localparam int ST_ACT      = 0;
    localparam int ST_ERR      = 1;
    localparam int ST_IRQ      = 2;
    localparam int ST_RW_LO    = 5;
    localparam int ST_RW_HI    = 6;
    localparam logic [7:0] BYTE_ABSENT = 8'hFF;

    typedef struct packed {
        logic       ctl_we;
        logic       st_we;
        logic       x1_we;
        logic       x3_we;
        logic [3:0] ptr_be;
    } chan_wsel_t;
endpackage

// File: rtl/bmdma_addr_decode.sv
// Module: turns a word address, write strobe and byte enables into per-channel
// register write selects and a read channel/word index.
// Assumes word 0 of a channel holds control/ext/status/ext and word 1 the pointer.
module bmdma_addr_decode
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int WA_W  = $clog2(NUM_CH * 2),
    localparam int CH_W  = (WA_W > 1) ? WA_W - 1 : 1
) (
    input  logic            wr,
    input  logic [WA_W-1:0] waddr,
    input  logic [3:0]      be,
    output chan_wsel_t      wsel [NUM_CH],
    output logic [CH_W-1:0] rd_ch,
    output logic            rd_word,
    output logic            rd_valid
);
    logic [CH_W-1:0] ch_idx;

    // Purpose: split the word address into channel index and word select.
    always_comb begin
        ch_idx   = CH_W'(waddr >> 1);
        rd_word  = waddr[0];
        rd_ch    = ch_idx;
        rd_valid = (int'(ch_idx) < NUM_CH);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        // Purpose: raise the write selects of channel c for the enabled lanes.
        always_comb begin
            logic hit;
            hit = wr && (int'(ch_idx) == c);
            wsel[c].ctl_we = hit && !waddr[0] && be[0];
            wsel[c].x1_we  = hit && !waddr[0] && be[1];
            wsel[c].st_we  = hit && !waddr[0] && be[2];
            wsel[c].x3_we  = hit && !waddr[0] && be[3];
            wsel[c].ptr_be = (hit && waddr[0]) ? be : 4'b0000;
        end
    end
endmodule

// File: rtl/bmdma_chan_regs.sv
// Module: registers of one DMA channel: control, status, table pointer,
// current pointer, optional extension bytes, and the go/stop pulses.
// Assumes strobes are single-cycle and synchronous to clk.
module bmdma_chan_regs
    import bmdma_pkg::*;
#(
    parameter bit EXT_BYTES = 1'b0,
    parameter int PTR_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chan_wsel_t       wsel,
    input  logic [31:0]      wdata,
    input  logic             done_stb,
    input  logic             err_stb,
    output logic             go_pulse,
    output logic             stop_pulse,
    output logic             dir,
    output logic [PTR_W-1:0] cur_ptr,
    output logic [31:0]      ctl_word,
    output logic [31:0]      ptr_word,
    output logic             active,
    output logic             irq_flag,
    output logic             err_flag
);
    localparam int LANES = PTR_W / 8;

    logic [7:0]       ctl_q, st_q, st_d;
    logic [PTR_W-1:0] ptr_q, ptr_d, cur_q;
    logic             go_q, stop_q, go_req, stop_req;
    logic [7:0]       x1_rd, x3_rd;
    logic [7:0]       ctl_wd, st_wd;

    assign ctl_wd = wdata[7:0];
    assign st_wd  = wdata[23:16];

    // Purpose: decide whether a control write starts or stops the channel.
    always_comb begin
        go_req   = wsel.ctl_we && ctl_wd[CTL_GO] && !st_q[ST_ACT];
        stop_req = wsel.ctl_we && !ctl_wd[CTL_GO];
    end

    // Purpose: merge host writes and engine strobes into the next status byte.
    always_comb begin
        st_d = 8'h00;
        if (go_req)
            st_d[ST_ACT] = 1'b1;
        else if (stop_req || done_stb)
            st_d[ST_ACT] = 1'b0;
        else
            st_d[ST_ACT] = st_q[ST_ACT];
        st_d[ST_ERR] = err_stb  || (st_q[ST_ERR] && !(wsel.st_we && st_wd[ST_ERR]));
        st_d[ST_IRQ] = done_stb || (st_q[ST_IRQ] && !(wsel.st_we && st_wd[ST_IRQ]));
        st_d[ST_RW_HI:ST_RW_LO] = wsel.st_we ? st_wd[ST_RW_HI:ST_RW_LO]
                                             : st_q[ST_RW_HI:ST_RW_LO];
    end

    // Purpose: merge enabled byte lanes into the pointer, low two bits forced zero.
    always_comb begin
        ptr_d = ptr_q;
        for (int k = 0; k < LANES; k++)
            if (wsel.ptr_be[k])
                ptr_d[8*k +: 8] = wdata[8*k +: 8];
        ptr_d[1:0] = 2'b00;
    end

    // Purpose: hold control, status, pointers and the engine pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= 8'h00;
            st_q   <= 8'h00;
            ptr_q  <= '0;
            cur_q  <= '0;
            go_q   <= 1'b0;
            stop_q <= 1'b0;
        end else begin
            if (wsel.ctl_we)
                ctl_q <= ctl_wd & CTL_KEEP;
            st_q   <= st_d;
            go_q   <= go_req;
            stop_q <= stop_req;
            if (|wsel.ptr_be) begin
                ptr_q <= ptr_d;
                cur_q <= ptr_d;
            end
        end
    end

    if (EXT_BYTES) begin : g_ext
        logic [7:0] x1_q, x3_q;
        // Purpose: store the two optional extension bytes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                x1_q <= 8'h00;
                x3_q <= 8'h00;
            end else begin
                if (wsel.x1_we) x1_q <= wdata[15:8];
                if (wsel.x3_we) x3_q <= wdata[31:24];
            end
        end
        assign x1_rd = x1_q;
        assign x3_rd = x3_q;
    end else begin : g_noext
        assign x1_rd = BYTE_ABSENT;
        assign x3_rd = BYTE_ABSENT;
    end

    assign go_pulse   = go_q;
    assign stop_pulse = stop_q;
    assign dir        = ctl_q[CTL_DIR];
    assign cur_ptr    = cur_q;
    assign ctl_word   = {x3_rd, st_q, x1_rd, ctl_q};
    assign ptr_word   = ptr_q;
    assign active     = st_q[ST_ACT];
    assign irq_flag   = st_q[ST_IRQ];
    assign err_flag   = st_q[ST_ERR];
endmodule

// File: rtl/bmdma_regfile.sv
// Module: top of the two-channel DMA register file. Decodes the host word
// port, instantiates one register set per channel and muxes read data.
// Assumes combinational reads; unmapped words read all ones.
module bmdma_regfile
    import bmdma_pkg::*;
#(
    parameter int NUM_CH    = 2,
    parameter bit EXT_BYTES = 1'b0,
    localparam int WA_W     = $clog2(NUM_CH * 2),
    localparam int CH_W     = (WA_W > 1) ? WA_W - 1 : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [WA_W-1:0]     bus_waddr,
    input  logic [3:0]          bus_be,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_CH-1:0]   eng_start,
    output logic [NUM_CH-1:0]   eng_cancel,
    output logic [NUM_CH-1:0]   eng_dir,
    output logic [NUM_CH*32-1:0] eng_cur_ptr,
    input  logic [NUM_CH-1:0]   eng_done,
    input  logic [NUM_CH-1:0]   eng_err
);
    chan_wsel_t        wsel [NUM_CH];
    logic [CH_W-1:0]   rd_ch;
    logic              rd_word, rd_valid;
    logic [31:0]       ctl_words [NUM_CH];
    logic [31:0]       ptr_words [NUM_CH];
    logic [NUM_CH-1:0] act_vec, irq_vec, err_vec;

    bmdma_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .wr       (bus_wr),
        .waddr    (bus_waddr),
        .be       (bus_be),
        .wsel     (wsel),
        .rd_ch    (rd_ch),
        .rd_word  (rd_word),
        .rd_valid (rd_valid)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        bmdma_chan_regs #(.EXT_BYTES(EXT_BYTES), .PTR_W(32)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .wsel       (wsel[c]),
            .wdata      (bus_wdata),
            .done_stb   (eng_done[c]),
            .err_stb    (eng_err[c]),
            .go_pulse   (eng_start[c]),
            .stop_pulse (eng_cancel[c]),
            .dir        (eng_dir[c]),
            .cur_ptr    (eng_cur_ptr[32*c +: 32]),
            .ctl_word   (ctl_words[c]),
            .ptr_word   (ptr_words[c]),
            .active     (act_vec[c]),
            .irq_flag   (irq_vec[c]),
            .err_flag   (err_vec[c])
        );
    end

    // Purpose: select the addressed word, all ones when out of range.
    always_comb begin
        bus_rdata = 32'hFFFF_FFFF;
        for (int c = 0; c < NUM_CH; c++)
            if (rd_valid && int'(rd_ch) == c)
                bus_rdata = rd_word ? ptr_words[c] : ctl_words[c];
    end
endmodule

// File: rtl/bmdma_regfile_chk.sv
// Module: protocol checker for bmdma_regfile, bound to every instance.
// Assumes reset is held for at least one clock edge.
module bmdma_regfile_chk #(
    parameter int NUM_CH = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_CH-1:0]     eng_start,
    input logic [NUM_CH-1:0]     eng_cancel,
    input logic [NUM_CH-1:0]     eng_done,
    input logic [NUM_CH-1:0]     eng_err,
    input logic [NUM_CH-1:0]     act_vec,
    input logic [NUM_CH-1:0]     irq_vec,
    input logic [NUM_CH-1:0]     err_vec,
    input logic [NUM_CH*32-1:0]  eng_cur_ptr
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        a_r3_stop_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
            eng_cancel[c] |-> !act_vec[c]);
        a_r4_go_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[c] |-> act_vec[c]);
        a_r4_go_only_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[c] |-> !$past(act_vec[c]));
        a_r4_go_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            eng_start[c] |=> !eng_start[c]);
        a_r3_go_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            !(eng_start[c] && eng_cancel[c]));
        a_r6_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
            eng_done[c] |=> irq_vec[c]);
        a_r6_err_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
            eng_err[c] |=> err_vec[c]);
        a_r7_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            eng_cur_ptr[32*c +: 2] == 2'b00);
    end
endmodule

bind bmdma_regfile bmdma_regfile_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_start   (eng_start),
    .eng_cancel  (eng_cancel),
    .eng_done    (eng_done),
    .eng_err     (eng_err),
    .act_vec     (act_vec),
    .irq_vec     (irq_vec),
    .err_vec     (err_vec),
    .eng_cur_ptr (eng_cur_ptr)
);

// File: tb/bmdma_regfile_bench.sv
`timescale 1ns/1ps
module bmdma_regfile_bench;
    localparam real TCLK = 8.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_waddr = 2'b00;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [1:0]  eng_done = 2'b00, eng_err = 2'b00;
    logic [31:0] rdata, rdata_x;
    logic [1:0]  start, cancel, dir;
    logic [63:0] cur;
    logic [1:0]  start_x, cancel_x, dir_x;
    logic [63:0] cur_x;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  m_ctl [2];
    logic [7:0]  m_st  [2];
    logic [7:0]  m_x1  [2];
    logic [7:0]  m_x3  [2];
    logic [31:0] m_ptr [2];
    logic [1:0]  m_go, m_stop;

    always #(TCLK/2) clk = ~clk;

    bmdma_regfile u_bmdma_regfile (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata),
        .eng_start(start), .eng_cancel(cancel), .eng_dir(dir),
        .eng_cur_ptr(cur), .eng_done(eng_done), .eng_err(eng_err)
    );

    bmdma_regfile #(.EXT_BYTES(1'b1)) u_bmdma_regfile_ext (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata_x),
        .eng_start(start_x), .eng_cancel(cancel_x), .eng_dir(dir_x),
        .eng_cur_ptr(cur_x), .eng_done(eng_done), .eng_err(eng_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected next status byte for one channel, from the requirements.
    function automatic logic [7:0] next_st(input logic [7:0] s, input logic go, input logic stop,
                                           input logic stw, input logic [7:0] d,
                                           input logic dn, input logic er);
        logic [7:0] n;
        n = 8'h00;
        n[0] = go ? 1'b1 : ((stop || dn) ? 1'b0 : s[0]);
        n[1] = er || (s[1] && !(stw && d[1]));
        n[2] = dn || (s[2] && !(stw && d[2]));
        n[6:5] = stw ? d[6:5] : s[6:5];
        return n;
    endfunction

    function automatic logic [31:0] next_ptr(input logic [31:0] p, input logic [3:0] b,
                                             input logic [31:0] d);
        logic [31:0] n;
        n = p;
        for (int k = 0; k < 4; k++) if (b[k]) n[8*k +: 8] = d[8*k +: 8];
        n[1:0] = 2'b00;
        return n;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_ctl[c] = 8'h00; m_st[c] = 8'h00; m_ptr[c] = 32'h0;
            m_x1[c] = 8'h00; m_x3[c] = 8'h00;
        end
        m_go = 2'b00; m_stop = 2'b00;
    endtask

    // Read back every register and compare the engine-side outputs.
    task automatic check_all();
        for (int c = 0; c < 2; c++) begin
            bus_waddr = {c[0], 1'b0};
            #1;
            chk("R2 control byte", {24'h0, rdata[7:0]}, {24'h0, m_ctl[c]});
            chk("R5 status byte", {24'h0, rdata[23:16]}, {24'h0, m_st[c]});
            chk("R9 absent ext bytes", {16'h0, rdata[31:24], rdata[15:8]}, 32'h0000FFFF);
            chk("R9 ext bytes", {16'h0, rdata_x[31:24], rdata_x[15:8]}, {16'h0, m_x3[c], m_x1[c]});
            bus_waddr = {c[0], 1'b1};
            #1;
            chk("R7 pointer", rdata, m_ptr[c]);
            chk("R8 current pointer", cur[32*c +: 32], m_ptr[c]);
            chk("R2 direction", {31'h0, dir[c]}, {31'h0, m_ctl[c][3]});
            chk("R4 go pulse", {31'h0, start[c]}, {31'h0, m_go[c]});
            chk("R3 stop pulse", {31'h0, cancel[c]}, {31'h0, m_stop[c]});
        end
    endtask

    // One bus/strobe cycle followed by a full read-back.
    task automatic step(input logic w, input logic [1:0] a, input logic [3:0] b,
                        input logic [31:0] d, input logic [1:0] dn, input logic [1:0] er);
        @(negedge clk);
        bus_wr = w; bus_waddr = a; bus_be = b; bus_wdata = d;
        eng_done = dn; eng_err = er;
        for (int c = 0; c < 2; c++) begin
            logic hit, cw, sw, go, stop;
            hit  = w && (a[1] == c[0]);
            cw   = hit && !a[0] && b[0];
            sw   = hit && !a[0] && b[2];
            go   = cw && d[0] && !m_st[c][0];
            stop = cw && !d[0];
            m_st[c] = next_st(m_st[c], go, stop, sw, d[23:16], dn[c], er[c]);
            if (cw) m_ctl[c] = d[7:0] & 8'h09;
            if (hit && !a[0] && b[1]) m_x1[c] = d[15:8];
            if (hit && !a[0] && b[3]) m_x3[c] = d[31:24];
            if (hit && a[0]) m_ptr[c] = next_ptr(m_ptr[c], b, d);
            m_go[c] = go; m_stop[c] = stop;
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0; eng_done = 2'b00; eng_err = 2'b00;
        check_all();
        m_go = 2'b00; m_stop = 2'b00;
    endtask

    initial begin
        #(TCLK * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int c = 0; c < 2; c++) begin
            bus_waddr = {c[0], 1'b0}; #1;
            chk("R1 reset control/status", {rdata[23:16], rdata[7:0]}, 16'h0);
            bus_waddr = {c[0], 1'b1}; #1;
            chk("R1 reset pointer", rdata, 32'h0);
            chk("R1 reset current pointer", cur[32*c +: 32], 32'h0);
        end
        chk("R1 no pulses", {start, cancel}, 4'h0);

        step(1, 2'b00, 4'h1, 32'h0000_00FF, 2'b00, 2'b00);   // R2, R4 go from idle
        chk("R4 active after go", {31'h0, m_st[0][0]}, 32'h1);
        step(1, 2'b00, 4'h1, 32'h0000_0001, 2'b00, 2'b00);   // R4 no go while active
        step(1, 2'b00, 4'h1, 32'h0000_0008, 2'b00, 2'b00);   // R3 stop
        step(1, 2'b00, 4'h4, 32'h00FF_0000, 2'b00, 2'b00);   // R5 status write
        step(0, 2'b00, 4'h0, 32'h0, 2'b01, 2'b01);           // R6 strobes
        step(1, 2'b00, 4'h4, 32'h0006_0000, 2'b01, 2'b01);   // R6 strobe beats clear
        step(1, 2'b00, 4'h4, 32'h0002_0000, 2'b00, 2'b00);   // R5 clear err only
        step(1, 2'b00, 4'h1, 32'h0000_0001, 2'b01, 2'b00);   // R6 go with completion
        step(1, 2'b01, 4'h1, 32'h0000_00FF, 2'b00, 2'b00);   // R7 byte, low bits forced
        step(1, 2'b01, 4'hC, 32'hABCD_0000, 2'b00, 2'b00);   // R7 halfword
        step(1, 2'b01, 4'hF, 32'h1234_5677, 2'b00, 2'b00);   // R8 word
        step(1, 2'b00, 4'h2, 32'h0000_5A00, 2'b00, 2'b00);   // R9 ext byte 1
        // R10: channel 1 stays untouched by all the channel 0 traffic above
        chk("R10 other channel pointer", cur[63:32], 32'h0);
        bus_waddr = 2'b10; #1;
        chk("R10 other channel control/status", {rdata[23:16], rdata[7:0]}, 16'h0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[3:2], r[7:4], $urandom,
                 (r[10:8] == 3'b000) ? 2'b01 : ((r[10:8] == 3'b001) ? 2'b10 : 2'b00),
                 (r[13:11] == 3'b000) ? r[15:14] : 2'b00);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule